// File: doc/BRIEF.md
# Low-Load Detector with Command Limiter

This block watches a fan or pump motor controller for a light-load operating point and, once that point has persisted long enough, caps the command that the controller passes downstream. The decision depends on which loop the controller runs. With speed regulation, light load means the rotor turns faster than 80 % of its configured ceiling while drawing less current than a threshold. With current regulation, light load means the rotor speed has reached a threshold.

The same threshold input therefore carries a current level in one mode and a speed level in the other. The threshold and the cap value both arrive as a 4-bit mantissa with a 4-bit exponent, and each expands to mantissa shifted left by exponent. A qualification counter requires the candidate condition to hold without a break before the flag is raised. The cap is released in the very cycle the candidate condition goes away.

While the flag is set, the outgoing command is the smaller of the incoming command and the cap value. In all other cycles the command passes through untouched.

Top module: `lowload_limiter`

## Requirements
- R1: After a synchronous active-low reset, `low_load_o` and `limit_active_o` are 0 and `cmd_o` equals `cmd_i`.
- R2: With `ctrl_mode_i` = 0 (speed regulation), the candidate condition is true when 5·`speed_i` > 4·`speed_max_i` and `current_i` is below the threshold.
- R3: In speed regulation, a speed of exactly 80 % of the maximum (5·speed = 4·max) is not a candidate, and neither is a current equal to the threshold.
- R4: With `ctrl_mode_i` = 1 (current regulation), the candidate condition is `speed_i` ≥ threshold. `current_i` and `speed_max_i` have no effect on the flag in this mode.
- R5: When the candidate condition is true in the cycle after some clock edge and stays true, `low_load_o` reads 1 after `qual_time_i` further rising edges. A `qual_time_i` of 0 sets the flag in the first candidate cycle.
- R6: When the candidate condition drops before qualification completes, the count restarts from zero, and a fresh unbroken run of `qual_time_i` edges is needed.
- R7: `low_load_o` falls in the same cycle in which the candidate condition becomes false, with no clock edge in between.
- R8: While `low_load_o` is 1, `cmd_o` = min(`cmd_i`, cap), and `limit_active_o` is 1 exactly when `cmd_i` > cap.
- R9: While `low_load_o` is 0, `cmd_o` equals `cmd_i` and `limit_active_o` is 0.
- R10: The threshold and the cap each equal mantissa << exponent, with the exponent unsigned in 0..15. The value saturates to all ones if it does not fit in `DATA_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_mode_i | input | 1 | 0 = speed regulation, 1 = current regulation |
| speed_i | input | DATA_W | Measured speed |
| speed_max_i | input | DATA_W | Configured maximum speed |
| current_i | input | DATA_W | Measured current amplitude |
| thr_mant_i | input | 4 | Threshold mantissa |
| thr_exp_i | input | 4 | Threshold exponent |
| qual_time_i | input | QUAL_W | Qualification time in clock cycles |
| cap_mant_i | input | 4 | Cap value mantissa |
| cap_exp_i | input | 4 | Cap value exponent |
| cmd_i | input | DATA_W | Incoming speed or current command |
| low_load_o | output | 1 | Qualified low-load flag |
| limit_active_o | output | 1 | The cap is actively lowering the command |
| cmd_o | output | DATA_W | Command after limiting |

## Verification
The assertions check several properties on every cycle:
- the output never exceeds the input command;
- the output never exceeds the cap while flagged;
- the command passes through unchanged while unflagged;
- a dropped candidate clears the counter;
- the flag stays low whenever the mode-specific comparison fails.

Only the directed scenarios can show the following:
- the exact cycle in which qualification completes for a given time;
- the exact 80 % and equal-threshold boundaries;
- that the counter restarts after a brief interruption;
- the arithmetic of the mantissa/exponent expansion at its largest value.

// File: rtl/lowload_pkg.sv
// Package: shared widths, mode encoding and sizing helpers for the
// low-load detector. Assumes mantissa and exponent fields of fixed width.
package lowload_pkg;
    localparam int MANT_W = 4;
    localparam int EXP_W  = 4;
    // Widest value mantissa << exponent can produce.
    localparam int FULL_W = MANT_W + (1 << EXP_W) - 1;

    typedef enum logic {
        LL_SPEED_REG   = 1'b0,
        LL_CURRENT_REG = 1'b1
    } ll_mode_e;
endpackage

// File: rtl/ll_mexp_expand.sv
// Module: expands a mantissa/exponent pair into a plain unsigned value,
// mantissa shifted left by the exponent. Assumes the exponent is unsigned.
// Saturates to all ones when the result does not fit DATA_W bits.
module ll_mexp_expand
    import lowload_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [DATA_W-1:0] val_o
);
    logic [FULL_W-1:0] wide_w;

    // Full-precision shift, never truncated.
    always_comb wide_w = FULL_W'(mant_i) << exp_i;

    generate
        if (DATA_W >= FULL_W) begin : g_fits
            // Value always fits: zero-extend.
            always_comb val_o = DATA_W'(wide_w);
        end else begin : g_sat
            // Value may overflow: clamp to the largest representable number.
            always_comb val_o = (|wide_w[FULL_W-1:DATA_W]) ? {DATA_W{1'b1}}
                                                          : wide_w[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ll_candidate.sv
// Module: mode-dependent low-load candidate comparison, purely combinational.
// Speed regulation: 5*speed > 4*max and current < threshold.
// Current regulation: speed >= threshold.
module ll_candidate
    import lowload_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              mode_i,
    input  logic [DATA_W-1:0] speed_i,
    input  logic [DATA_W-1:0] speed_max_i,
    input  logic [DATA_W-1:0] current_i,
    input  logic [DATA_W-1:0] thr_i,
    output logic              cand_o
);
    localparam int PROD_W = DATA_W + 3;

    logic [PROD_W-1:0] speed_x5_w;
    logic [PROD_W-1:0] max_x4_w;

    // Integer form of the 80 % comparison, with no division.
    always_comb begin
        speed_x5_w = (PROD_W'(speed_i) << 2) + PROD_W'(speed_i);
        max_x4_w   = PROD_W'(speed_max_i) << 2;
    end

    // Select the comparison that the active regulation loop calls for.
    always_comb begin
        unique case (ll_mode_e'(mode_i))
            LL_SPEED_REG:   cand_o = (speed_x5_w > max_x4_w) && (current_i < thr_i);
            LL_CURRENT_REG: cand_o = (speed_i >= thr_i);
            default:        cand_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ll_qual_timer.sv
// Module: qualification counter. It counts consecutive clock edges during
// which the candidate holds, saturating at the qualification time.
// Assumes the candidate is stable between clock edges.
// The flag is combinational in the candidate so removal is immediate.
module ll_qual_timer #(
    parameter int QUAL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_i,
    input  logic [QUAL_W-1:0] qual_time_i,
    output logic              low_load_o
);
    logic [QUAL_W-1:0] cnt_q;
    logic              done_w;

    // Qualification reached (tolerates a qual time lowered mid-count).
    always_comb done_w = (cnt_q >= qual_time_i);

    // Count while the candidate holds, restart when it drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !cand_i) begin
            cnt_q <= '0;
        end else if (!done_w) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag follows the candidate directly once qualified.
    always_comb low_load_o = cand_i && done_w;

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_i |=> (cnt_q == '0));

    assert_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (low_load_o && qual_time_i != '0) |-> $past(cand_i));
endmodule

// File: rtl/ll_cmd_limiter.sv
// Module: applies the low-load cap to the command. Output is the smaller of
// the command and the cap while flagged, and the command unchanged otherwise.
module ll_cmd_limiter #(
    parameter int DATA_W = 20
) (
    input  logic              low_load_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic [DATA_W-1:0] cap_i,
    output logic [DATA_W-1:0] cmd_o,
    output logic              limit_active_o
);
    logic over_w;

    // Command exceeds the cap.
    always_comb over_w = (cmd_i > cap_i);

    // Clamp only while the flag is set.
    always_comb begin
        limit_active_o = low_load_i && over_w;
        cmd_o          = limit_active_o ? cap_i : cmd_i;
    end
endmodule

// File: rtl/lowload_limiter.sv
// Module: top of the low-load detector and limiter. It expands the threshold
// and the cap, evaluates the mode-dependent candidate, qualifies it over
// time and limits the command. Assumes all inputs are synchronous to clk.
module lowload_limiter
    import lowload_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int QUAL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_mode_i,
    input  logic [DATA_W-1:0] speed_i,
    input  logic [DATA_W-1:0] speed_max_i,
    input  logic [DATA_W-1:0] current_i,
    input  logic [3:0]        thr_mant_i,
    input  logic [3:0]        thr_exp_i,
    input  logic [QUAL_W-1:0] qual_time_i,
    input  logic [3:0]        cap_mant_i,
    input  logic [3:0]        cap_exp_i,
    input  logic [DATA_W-1:0] cmd_i,
    output logic              low_load_o,
    output logic              limit_active_o,
    output logic [DATA_W-1:0] cmd_o
);
    logic [DATA_W-1:0] thr_w;
    logic [DATA_W-1:0] cap_w;
    logic              cand_w;

    ll_mexp_expand #(.DATA_W(DATA_W)) thr_exp_i0 (
        .mant_i(thr_mant_i), .exp_i(thr_exp_i), .val_o(thr_w)
    );

    ll_mexp_expand #(.DATA_W(DATA_W)) cap_exp_i0 (
        .mant_i(cap_mant_i), .exp_i(cap_exp_i), .val_o(cap_w)
    );

    ll_candidate #(.DATA_W(DATA_W)) cand_i0 (
        .mode_i(ctrl_mode_i), .speed_i(speed_i), .speed_max_i(speed_max_i),
        .current_i(current_i), .thr_i(thr_w), .cand_o(cand_w)
    );

    ll_qual_timer #(.QUAL_W(QUAL_W)) timer_i0 (
        .clk(clk), .rst_n(rst_n), .cand_i(cand_w),
        .qual_time_i(qual_time_i), .low_load_o(low_load_o)
    );

    ll_cmd_limiter #(.DATA_W(DATA_W)) limit_i0 (
        .low_load_i(low_load_o), .cmd_i(cmd_i), .cap_i(cap_w),
        .cmd_o(cmd_o), .limit_active_o(limit_active_o)
    );

    assert_no_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o <= cmd_i);

    assert_under_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_load_o |-> (cmd_o <= cap_w));

    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !low_load_o |-> (cmd_o == cmd_i && !limit_active_o));

    assert_drop_immediate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_w |-> !low_load_o);

    assert_speed_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode_i == 1'b0 && current_i >= thr_w) |-> !low_load_o);

    assert_current_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode_i == 1'b1 && speed_i < thr_w) |-> !low_load_o);
endmodule

// File: tb/lowload_limiter_tb.sv
// Directed bench for lowload_limiter. Inputs change 1 time unit after a
// rising edge; outputs are sampled 3 units after that edge.
module lowload_limiter_tb_top;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 20;
    localparam int QUAL_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_mode_i = 1'b0;
    logic [DATA_W-1:0] speed_i = '0;
    logic [DATA_W-1:0] speed_max_i = '0;
    logic [DATA_W-1:0] current_i = '0;
    logic [3:0]        thr_mant_i = '0;
    logic [3:0]        thr_exp_i = '0;
    logic [QUAL_W-1:0] qual_time_i = '0;
    logic [3:0]        cap_mant_i = '0;
    logic [3:0]        cap_exp_i = '0;
    logic [DATA_W-1:0] cmd_i = '0;
    logic              low_load_o;
    logic              limit_active_o;
    logic [DATA_W-1:0] cmd_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    lowload_limiter #(.DATA_W(DATA_W), .QUAL_W(QUAL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_mode_i(ctrl_mode_i),
        .speed_i(speed_i), .speed_max_i(speed_max_i), .current_i(current_i),
        .thr_mant_i(thr_mant_i), .thr_exp_i(thr_exp_i),
        .qual_time_i(qual_time_i), .cap_mant_i(cap_mant_i),
        .cap_exp_i(cap_exp_i), .cmd_i(cmd_i), .low_load_o(low_load_o),
        .limit_active_o(limit_active_o), .cmd_o(cmd_o)
    );

    task automatic chk(input string req, input string what,
                       input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Advance one clock and move to the input-drive point.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Sample point, 2 units after the drive point.
    task automatic settle();
        #2;
    endtask

    task automatic idle();
        tick();
        ctrl_mode_i = 1'b0; speed_i = '0; speed_max_i = '0; current_i = '0;
        settle();
    endtask

    task automatic t_reset();
        cmd_i = 20'd123;
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        chk("R1", "low_load", low_load_o, 0);
        chk("R1", "limit_active", limit_active_o, 0);
        chk("R1", "cmd_o", cmd_o, 123);
    endtask

    // Speed regulation: qualification, clamp, immediate removal, restart.
    task automatic t_speed_mode();
        idle();
        tick();
        ctrl_mode_i = 1'b0; speed_max_i = 20'd1000; speed_i = 20'd801;
        thr_mant_i = 4'd5; thr_exp_i = 4'd4;    // threshold 80
        cap_mant_i = 4'd3; cap_exp_i = 4'd5;    // cap 96
        current_i = 20'd79; qual_time_i = 16'd3; cmd_i = 20'd500;
        settle();
        for (int k = 0; k < 3; k++) begin
            chk("R5", "low_load before qualification", low_load_o, 0);
            chk("R9", "cmd_o passes", cmd_o, 500);
            tick(); settle();
        end
        chk("R2", "low_load after 3 edges", low_load_o, 1);
        chk("R8", "cmd_o capped", cmd_o, 96);
        chk("R8", "limit_active", limit_active_o, 1);
        tick();
        current_i = 20'd80;                     // equal to threshold
        settle();
        chk("R7", "flag falls same cycle", low_load_o, 0);
        chk("R3", "current equal threshold", cmd_o, 500);
        tick();
        current_i = 20'd79;
        settle();
        chk("R6", "restart from zero", low_load_o, 0);
        tick(); tick(); settle();
        chk("R6", "still counting", low_load_o, 0);
        tick(); settle();
        chk("R6", "qualified again", low_load_o, 1);
    endtask

    // Exactly 80 % is not a candidate; qual time 0 is immediate.
    task automatic t_boundary();
        idle();
        tick();
        ctrl_mode_i = 1'b0; speed_max_i = 20'd1000; speed_i = 20'd800;
        thr_mant_i = 4'd5; thr_exp_i = 4'd4; current_i = 20'd0;
        qual_time_i = 16'd0; cmd_i = 20'd1000;
        settle();
        chk("R3", "speed at exactly 80%", low_load_o, 0);
        tick();
        speed_i = 20'd801;
        settle();
        chk("R5", "qual time 0 immediate", low_load_o, 1);
        chk("R8", "cap applied", cmd_o, 96);
    endtask

    // Interrupted candidate must restart qualification.
    task automatic t_restart();
        idle();
        tick();
        ctrl_mode_i = 1'b0; speed_max_i = 20'd1000; speed_i = 20'd900;
        current_i = 20'd10; qual_time_i = 16'd4;
        settle();
        tick(); tick(); tick(); settle();
        chk("R6", "3 of 4 edges", low_load_o, 0);
        tick();
        speed_i = 20'd700;                      // break the run
        settle();
        chk("R6", "break", low_load_o, 0);
        tick();
        speed_i = 20'd900;
        settle();
        tick(); tick(); tick(); settle();
        chk("R6", "3 edges after break", low_load_o, 0);
        tick(); settle();
        chk("R6", "4 edges after break", low_load_o, 1);
    endtask

    // Current regulation: threshold is a speed; current and max ignored.
    task automatic t_current_mode();
        idle();
        tick();
        ctrl_mode_i = 1'b1; thr_mant_i = 4'd1; thr_exp_i = 4'd8;   // 256
        speed_i = 20'd255; speed_max_i = 20'd0; current_i = 20'hFFFFF;
        qual_time_i = 16'd0; cmd_i = 20'd50;
        settle();
        chk("R4", "speed below threshold", low_load_o, 0);
        tick();
        speed_i = 20'd256;
        settle();
        chk("R4", "speed reaches threshold, current ignored", low_load_o, 1);
        chk("R8", "cmd below cap passes", cmd_o, 50);
        chk("R8", "no active limiting", limit_active_o, 0);
    endtask

    // Largest mantissa and exponent.
    task automatic t_expand();
        idle();
        tick();
        ctrl_mode_i = 1'b1; thr_mant_i = 4'd15; thr_exp_i = 4'd15;  // 491520
        cap_mant_i = 4'd15; cap_exp_i = 4'd1;                       // 30
        speed_i = 20'd491519; qual_time_i = 16'd0; cmd_i = 20'd999999;
        settle();
        chk("R10", "one below max threshold", low_load_o, 0);
        chk("R9", "unflagged passes", cmd_o, 999999);
        tick();
        speed_i = 20'd491520;
        settle();
        chk("R10", "at max threshold", low_load_o, 1);
        chk("R10", "cap 15<<1", cmd_o, 30);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_speed_mode();
                t_boundary();
                t_restart();
                t_current_mode();
                t_expand();
            end
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule